// File: doc/BRIEF.md
# Serial EEPROM Access Sequencer

This block turns one host request into the full command sequence that a serial EEPROM on a two-wire bus needs. It sits above a byte engine that handles the bit timing. The host supplies a start byte address, a byte count, a direction and the part type: 2 KB, 8 KB or 16 KB. The sequencer then drives the engine one command at a time: start (which also serves as repeated start), write a byte and report its acknowledge, read a byte with or without acknowledge, and stop.

For each command the sequencer builds the device-select byte. On the two smaller parts it folds the high address bits into that byte. A read begins with an addressing-only write phase, followed by a repeated start. A write is split at page boundaries, and after each burst the sequencer waits for the part's internal programming time. When an addressing attempt or a data byte is refused, the sequencer retries. Write data is fetched by index, through `wr_idx` and `wr_data`, so that a restarted write can replay its bytes from the first one. Each read byte is handed out with a one-cycle strobe.

Top module: `i2c_eeprom_seq`

## Requirements
- R1: On the 2 KB and 8 KB parts, the select byte is the base value (8'hA0 for 2 KB, `part_sel`=0; 8'h80 for 8 KB, `part_sel`=1) ORed with address bits [13:8] shifted up by one. Bit 0 is 0 for the addressing phase and 1 for the read phase. The low address byte follows as the only offset byte.
- R2: On the 16 KB part (`part_sel`=2), the addressing phase is: start, 8'hA0, the high address byte, the low address byte. The acknowledge of that first select byte is ignored. The read phase uses 8'hA1.
- R3: A read is: addressing phase, repeated start, read select, one read command per byte, then stop. Every byte except the last is read with `eng_ack_out`=1. Each byte appears on `rd_data` with a one-cycle `rd_valid`.
- R4: A read that would run past the end of the part is shortened to the bytes that remain.
- R5: A write sends data bytes until the count is used up, the next address is a multiple of the page size (16 on the 2 KB and 8 KB parts, 64 on the 16 KB part), or the part ends. Each burst ends with a stop. At least `wc_wait_us` ticks of `us_tick` follow the stop before the next start or before completion.
- R6: An addressing attempt fails on a refused select byte (small parts), a refused high byte (16 KB part) or a refused offset byte. After a failure the sequencer issues a stop and tries again. When the select byte or high byte was refused, it first waits BACKOFF_STEP_US ticks multiplied by the index of the failed attempt, counting from 0. After MAX_TRIES (10) failed attempts it completes with error code 1 and no further backoff.
- R7: A refused data byte during a write causes a stop and the write-cycle wait. The whole write then restarts from the original address and byte index 0. If all 10 whole-write attempts fail, the access completes with error code 2.
- R8: A start address at or beyond the part size, or `part_sel`=3, completes with error code 3 and no bus command. A zero count in range completes with code 0 and no bus command.
- R9: Engine ops are coded 0 start, 1 write byte, 2 read byte, 3 stop. A command is held until `eng_done`. `busy` is high from an accepted request through the one-cycle `done` pulse. `err` is 0 on success. A request made while busy is ignored. No command is issued while idle.
- R10: `addr_retries` reports how many attempts failed in the last addressing phase of the access: 10 after an addressing failure, 0 when the first attempt succeeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an access (sampled while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Start byte address |
| req_count | input | 15 | Number of bytes |
| part_sel | input | 2 | 0 = 2 KB, 1 = 8 KB, 2 = 16 KB, 3 = none |
| wc_wait_us | input | 20 | Write-cycle wait in microsecond ticks |
| us_tick | input | 1 | One-cycle microsecond enable |
| wr_idx | output | 15 | Index of the write byte wanted |
| wr_data | input | 8 | Write byte for `wr_idx` |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | Completion pulse |
| err | output | 2 | Completion code: 0 ok, 1 address fail, 2 data refused, 3 out of range |
| addr_retries | output | 4 | Failed addressing attempts, last phase |
| eng_valid | output | 1 | Command to byte engine valid |
| eng_op | output | 2 | Command code |
| eng_wdata | output | 8 | Byte to send |
| eng_ack_out | output | 1 | Acknowledge the byte read |
| eng_done | input | 1 | Engine finished the command |
| eng_ack_in | input | 1 | Acknowledge seen for a written byte |
| eng_rdata | input | 8 | Byte read by the engine |

## Verification
The bench aims at the page fold in the select byte. A sequencer that shifts the wrong way, or adds page bits on the 16 KB part, addresses the wrong page. It also covers writes that cross a 16- or 64-byte boundary or run into the end of the part; a fault there would show as a burst wrapping inside the part's page buffer. On reads it targets the truncation at the end of the part and the missing acknowledge on the last byte, which a faulty design would either overrun or leave the bus stuck on. The retry paths are checked as well. An ignored 16 KB select refusal, an offset refusal with no backoff, the backoff length and restarts from the original address would each show as a wrong command stream or a wrong error code.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
    localparam int ADDR_W = 14;
    localparam int CNT_W  = 15;
    localparam int WAIT_W = 20;

    typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} bus_op_e;
    typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_ADDR = 2'd1, ERR_DATA = 2'd2, ERR_RANGE = 2'd3} acc_err_e;
    typedef enum logic [1:0] {PART_2K = 2'd0, PART_8K = 2'd1, PART_16K = 2'd2, PART_NONE = 2'd3} part_e;
    typedef enum logic [3:0] {
        S_IDLE, S_ASTART, S_ASEL, S_AHI, S_ALO, S_RSTART, S_RSEL,
        S_RDATA, S_WDATA, S_STOP, S_WAIT, S_DONE
    } seq_st_e;
    typedef enum logic [1:0] {NX_DONE, NX_WAIT_DONE, NX_WAIT_ADDR} after_stop_e;

    typedef struct packed {
        logic [ADDR_W:0] limit;
        logic [6:0]      page_mask;
        logic [7:0]      sel_base;
        logic            long_addr;
    } part_info_t;

    function automatic part_info_t part_lookup(part_e p);
        part_info_t i;
        i.page_mask = 7'd15;
        i.sel_base  = 8'hA0;
        i.long_addr = 1'b0;
        case (p)
            PART_2K:  i.limit = (ADDR_W+1)'(2048);
            PART_8K:  begin i.limit = (ADDR_W+1)'(8192); i.sel_base = 8'h80; end
            PART_16K: begin i.limit = (ADDR_W+1)'(16384); i.page_mask = 7'd63; i.long_addr = 1'b1; end
            default:  i.limit = '0;
        endcase
        return i;
    endfunction
endpackage

// File: rtl/eeseq_part_decode.sv
module eeseq_part_decode
    import eeseq_pkg::*;
(
    input  part_e      part,
    output part_info_t info
);
    always_comb info = part_lookup(part);
endmodule

// File: rtl/eeseq_us_timer.sv
module eeseq_us_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_eeprom_seq.sv
module i2c_eeprom_seq
    import eeseq_pkg::*;
#(
    parameter int MAX_TRIES       = 10,
    parameter int BACKOFF_STEP_US = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [1:0]        part_sel,
    input  logic [WAIT_W-1:0] wc_wait_us,
    input  logic              us_tick,
    output logic [CNT_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err,
    output logic [3:0]        addr_retries,
    output logic              eng_valid,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_wdata,
    output logic              eng_ack_out,
    input  logic              eng_done,
    input  logic              eng_ack_in,
    input  logic [7:0]        eng_rdata
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_st_e         st_q;
    after_stop_e     nx_q;
    acc_err_e        perr_q;
    part_info_t      info_in, info_q;
    logic            wr_q;
    logic [ADDR_W:0] start_q, cur_q, cur_nxt;
    logic [CNT_W-1:0] cnt_q, idx_q, remain;
    logic [TRY_W-1:0] atry_q, wtry_q;
    logic [WAIT_W-1:0] wait_q, backoff;
    logic [7:0]      sel_w;
    logic            tmr_zero, tmr_load, burst_last, burst_end;

    eeseq_part_decode u_dec (.part(part_e'(part_sel)), .info(info_in));

    assign tmr_load = (st_q == S_STOP) && eng_done && (nx_q != NX_DONE);

    eeseq_us_timer #(.W(WAIT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(wait_q),
        .tick(us_tick), .zero(tmr_zero)
    );

    assign remain     = CNT_W'(info_in.limit - {1'b0, req_addr});
    assign cur_nxt    = cur_q + 1'b1;
    assign burst_last = (idx_q + 1'b1 == cnt_q) || (cur_nxt == info_q.limit);
    assign burst_end  = burst_last || ((cur_nxt[6:0] & info_q.page_mask) == 7'd0);
    assign backoff    = WAIT_W'(BACKOFF_STEP_US) * WAIT_W'(atry_q);
    assign sel_w      = info_q.long_addr ? info_q.sel_base
                                         : (info_q.sel_base | {1'b0, cur_q[13:8], 1'b0});

    // Command presented to the byte engine, held until eng_done.
    always_comb begin
        eng_valid   = 1'b1;
        eng_op      = OP_WRITE;
        eng_wdata   = 8'h00;
        eng_ack_out = 1'b0;
        case (st_q)
            S_ASTART, S_RSTART: eng_op = OP_START;
            S_ASEL:  eng_wdata = sel_w;
            S_AHI:   eng_wdata = {2'b00, cur_q[13:8]};
            S_ALO:   eng_wdata = cur_q[7:0];
            S_RSEL:  eng_wdata = sel_w | 8'h01;
            S_WDATA: eng_wdata = wr_data;
            S_RDATA: begin eng_op = OP_READ; eng_ack_out = (idx_q != cnt_q - 1'b1); end
            S_STOP:  eng_op = OP_STOP;
            default: eng_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE; nx_q <= NX_DONE; perr_q <= ERR_NONE; info_q <= '0;
            wr_q <= 1'b0; start_q <= '0; cur_q <= '0; cnt_q <= '0; idx_q <= '0;
            atry_q <= '0; wtry_q <= '0; wait_q <= '0; rd_valid <= 1'b0;
            rd_data <= 8'h00; err <= 2'd0; addr_retries <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (st_q)
                S_IDLE: if (req) begin
                    info_q <= info_in; wr_q <= req_write; perr_q <= ERR_NONE;
                    start_q <= {1'b0, req_addr}; cur_q <= {1'b0, req_addr};
                    idx_q <= '0; atry_q <= '0; wtry_q <= '0;
                    cnt_q <= (!req_write && req_count > remain) ? remain : req_count;
                    if ({1'b0, req_addr} >= info_in.limit) begin
                        perr_q <= ERR_RANGE; st_q <= S_DONE;
                    end else if (req_count == '0) st_q <= S_DONE;
                    else st_q <= S_ASTART;
                end
                S_ASTART: if (eng_done) st_q <= S_ASEL;
                S_ASEL, S_AHI: if (eng_done) begin
                    if (st_q == S_ASEL && info_q.long_addr) st_q <= S_AHI;
                    else if (eng_ack_in) st_q <= S_ALO;
                    else begin
                        st_q <= S_STOP; wait_q <= backoff; atry_q <= atry_q + 1'b1;
                        if (atry_q + 1'b1 == TRY_W'(MAX_TRIES)) begin
                            nx_q <= NX_DONE; perr_q <= ERR_ADDR; addr_retries <= 4'(MAX_TRIES);
                        end else nx_q <= NX_WAIT_ADDR;
                    end
                end
                S_ALO: if (eng_done) begin
                    if (eng_ack_in) begin
                        addr_retries <= 4'(atry_q);
                        st_q <= wr_q ? S_WDATA : S_RSTART;
                    end else begin
                        st_q <= S_STOP; wait_q <= '0; atry_q <= atry_q + 1'b1;
                        if (atry_q + 1'b1 == TRY_W'(MAX_TRIES)) begin
                            nx_q <= NX_DONE; perr_q <= ERR_ADDR; addr_retries <= 4'(MAX_TRIES);
                        end else nx_q <= NX_WAIT_ADDR;
                    end
                end
                S_RSTART: if (eng_done) st_q <= S_RSEL;
                S_RSEL: if (eng_done) begin
                    st_q <= eng_ack_in ? S_RDATA : S_STOP;
                    nx_q <= NX_DONE;
                    if (!eng_ack_in) perr_q <= ERR_ADDR;
                end
                S_RDATA: if (eng_done) begin
                    rd_valid <= 1'b1; rd_data <= eng_rdata; idx_q <= idx_q + 1'b1;
                    if (idx_q + 1'b1 == cnt_q) begin st_q <= S_STOP; nx_q <= NX_DONE; end
                end
                S_WDATA: if (eng_done) begin
                    atry_q <= '0; wait_q <= wc_wait_us;
                    if (eng_ack_in) begin
                        idx_q <= idx_q + 1'b1; cur_q <= cur_nxt;
                        if (burst_end) begin
                            st_q <= S_STOP;
                            nx_q <= burst_last ? NX_WAIT_DONE : NX_WAIT_ADDR;
                        end
                    end else begin
                        st_q <= S_STOP; idx_q <= '0; cur_q <= start_q; wtry_q <= wtry_q + 1'b1;
                        if (wtry_q + 1'b1 == TRY_W'(MAX_TRIES)) begin
                            nx_q <= NX_WAIT_DONE; perr_q <= ERR_DATA;
                        end else nx_q <= NX_WAIT_ADDR;
                    end
                end
                S_STOP: if (eng_done) st_q <= (nx_q == NX_DONE) ? S_DONE : S_WAIT;
                S_WAIT: if (tmr_zero) st_q <= (nx_q == NX_WAIT_DONE) ? S_DONE : S_ASTART;
                S_DONE: begin err <= perr_q; st_q <= S_IDLE; end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign wr_idx = idx_q;
    assign busy   = (st_q != S_IDLE);
    assign done   = (st_q == S_DONE);
endmodule

// File: rtl/i2c_eeprom_seq_chk.sv
module i2c_eeprom_seq_chk #(
    parameter int MAX_TRIES = 10
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       eng_valid,
    input logic [1:0] eng_op,
    input logic [7:0] eng_wdata,
    input logic       eng_done,
    input logic       rd_valid,
    input logic [3:0] addr_retries
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_valid);
    assert_cmd_held_R9: assert property (@(posedge clk) disable iff (rst)
        (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_op) && $stable(eng_wdata)));
    assert_rd_from_read_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(eng_done && eng_op == 2'd2));
    assert_retry_bound_R10: assert property (@(posedge clk) disable iff (rst)
        addr_retries <= 4'(MAX_TRIES));
endmodule

bind i2c_eeprom_seq i2c_eeprom_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .eng_valid(eng_valid),
    .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_done(eng_done),
    .rd_valid(rd_valid), .addr_retries(addr_retries)
);

// File: tb/i2c_eeprom_seq_test.sv
module i2c_eeprom_seq_test;
    timeunit 1ns; timeprecision 1ps;

    logic clk = 0, rst = 1;
    logic req = 0, req_write = 0, us_tick = 1;
    logic [13:0] req_addr = 0;
    logic [14:0] req_count = 0, wr_idx;
    logic [1:0]  part_sel = 0, eng_op, err;
    logic [19:0] wc_wait_us = 0;
    logic [7:0]  wr_data, rd_data, eng_wdata, eng_rdata = 0;
    logic rd_valid, busy, done, eng_valid, eng_ack_out;
    logic eng_done = 0, eng_ack_in = 0;
    logic [3:0] addr_retries;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int exp_q[$], rd_q[$], nack_list[$];
    int nack_mode = 0, wr_no = 0, rd_seed = 8'h40;
    int last_stop = 0, chk_gap = 0, gap_w = 0;
    bit had_stop = 0, eng_bsy = 0;
    int lat = 0;

    always #10 clk = ~clk;

    i2c_eeprom_seq uut (.*);

    function automatic logic [7:0] wd(int i); return 8'(i * 7 + 3); endfunction
    assign wr_data = wd(int'(wr_idx));

    task automatic chk(bit ok, string rq, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    function automatic int lim(int p); return p == 0 ? 2048 : p == 1 ? 8192 : 16384; endfunction
    function automatic int pg(int p); return p == 2 ? 64 : 16; endfunction
    function automatic int base(int p); return p == 1 ? 'h80 : 'hA0; endfunction

    task automatic e(int op, int d, int a); exp_q.push_back((op << 9) | (d << 1) | a); endtask

    task automatic e_addr(int a, int p);
        e(0, 0, 0);
        if (p == 2) begin e(1, 'hA0, 0); e(1, a >> 8, 0); end
        else e(1, (base(p) | ((a >> 8) << 1)) & 255, 0);
        e(1, a & 255, 0);
    endtask

    task automatic e_read(int a, int n, int p);
        e_addr(a, p);
        e(0, 0, 0);
        e(1, p == 2 ? 'hA1 : ((base(p) | ((a >> 8) << 1) | 1) & 255), 0);
        for (int i = 0; i < n; i++) e(2, 0, i != n - 1);
        e(3, 0, 0);
    endtask

    task automatic e_write(int a, int n, int p);
        int cur = a, i = 0;
        while (i < n && cur < lim(p)) begin
            e_addr(cur, p);
            do begin e(1, wd(i), 0); i++; cur++; end
            while (i < n && cur % pg(p) != 0 && cur < lim(p));
            e(3, 0, 0);
        end
    endtask

    function automatic bit nack_now(int k);
        case (nack_mode)
            1: begin foreach (nack_list[j]) if (nack_list[j] == k) return 1; return 0; end
            2: return (k % 3) == 2;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    // Byte engine model: compares every issued command with the expected stream.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        eng_done <= 1'b0;
        if (rst) eng_bsy = 0;
        else if (eng_bsy) begin
            if (lat == 0) begin eng_done <= 1'b1; eng_bsy = 0; end
            else lat = lat - 1;
        end else if (eng_valid && !eng_done) begin
            int act;
            act = (eng_op == 2'd1) ? ((1 << 9) | (eng_wdata << 1))
                : (eng_op == 2'd2) ? ((2 << 9) | eng_ack_out) : (int'(eng_op) << 9);
            if (exp_q.size() == 0) chk(0, "R9", "unexpected command", act, 0);
            else begin
                int ex;
                ex = exp_q.pop_front();
                chk(act == ex, "R1/R2/R3/R5", "command stream", act, ex);
            end
            if (eng_op == 2'd1) begin eng_ack_in <= !nack_now(wr_no); wr_no++; end
            if (eng_op == 2'd2) begin eng_rdata <= 8'(rd_seed); rd_q.push_back(rd_seed & 255); rd_seed++; end
            if (eng_op == 2'd0 && had_stop && chk_gap != 0)
                chk(cyc - last_stop >= gap_w && cyc - last_stop <= gap_w + 12, "R5",
                    "stop-to-start gap", cyc - last_stop, gap_w);
            if (eng_op == 2'd3) begin last_stop = cyc; had_stop = 1; end
            eng_bsy = 1; lat = 1;
        end
    end

    always @(negedge clk) if (!rst && rd_valid) begin
        if (rd_q.size() == 0) chk(0, "R3", "unexpected rd_valid", rd_data, 0);
        else begin
            int ex;
            ex = rd_q.pop_front();
            chk(rd_data == 8'(ex), "R3", "read byte", rd_data, ex);
        end
    end

    task automatic run(bit w, int a, int n, int p, int wc, int eerr, int eret, string rq,
                       bit dup, output int elapsed);
        int t = 0, t0;
        wr_no = 0; had_stop = 0; gap_w = wc;
        @(negedge clk);
        req_write = w; req_addr = 14'(a); req_count = 15'(n); part_sel = 2'(p);
        wc_wait_us = 20'(wc); req = 1; t0 = cyc;
        @(negedge clk); req = 0;
        chk(busy == 1'b1, "R9", "busy after request", busy, 1);
        while (!done && t < 100000) begin
            @(negedge clk); t++;
            if (dup && t == 30) begin req = 1; req_addr = 14'(a + 1); @(negedge clk); req = 0; end
        end
        elapsed = cyc - t0;
        chk(done == 1'b1, rq, "done seen", done, 1);
        @(negedge clk);
        chk(err == 2'(eerr), rq, "error code", err, eerr);
        if (eret >= 0) chk(addr_retries == 4'(eret), "R10", "address retries", addr_retries, eret);
        chk(exp_q.size() == 0, rq, "commands missing", exp_q.size(), 0);
        chk(rd_q.size() == 0, "R3", "read bytes not delivered", rd_q.size(), 0);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9", "idle after access", busy, 0);
        exp_q.delete(); rd_q.delete(); nack_mode = 0; nack_list.delete(); chk_gap = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int el;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !eng_valid && !rd_valid, "R9", "reset state",
            {busy, done, eng_valid, rd_valid}, 0);

        e_read('h3F5, 3, 0);  run(0, 'h3F5, 3, 0, 0, 0, 0, "R1", 0, el);
        e_read('h1ABC, 2, 1); run(0, 'h1ABC, 2, 1, 0, 0, 0, "R1", 0, el);
        e_read('h1234, 4, 2); run(0, 'h1234, 4, 2, 0, 0, 0, "R2", 0, el);
        // R2: refused first select byte on the 16 KB part changes nothing
        nack_mode = 1; nack_list.push_back(0);
        e_read('h1234, 1, 2); run(0, 'h1234, 1, 2, 0, 0, 0, "R2", 0, el);
        // R4: truncation at the end of the part
        e_read(2040, 8, 0);    run(0, 2040, 20, 0, 0, 0, 0, "R4", 0, el);
        e_read(16383, 1, 2);   run(0, 16383, 5, 2, 0, 0, 0, "R4", 0, el);
        // R5: page-split writes with write-cycle wait
        chk_gap = 1; e_write('h0C, 10, 0); run(1, 'h0C, 10, 0, 25, 0, 0, "R5", 0, el);
        chk_gap = 1; e_write(60, 70, 2);   run(1, 60, 70, 2, 40, 0, 0, "R5", 0, el);
        e_write(2046, 5, 0);               run(1, 2046, 5, 0, 3, 0, 0, "R5", 0, el);
        // R6 / R10: select refused, then offset refused, then success
        nack_mode = 1; nack_list.push_back(0); nack_list.push_back(2);
        e(0,0,0); e(1,'hA0,0); e(3,0,0);
        e(0,0,0); e(1,'hA0,0); e(1,'h10,0); e(3,0,0);
        e_read('h10, 1, 0);
        run(0, 'h10, 1, 0, 0, 0, 2, "R6", 0, el);
        // R6: every select refused -> address failure after backoff
        nack_mode = 3;
        for (int i = 0; i < 10; i++) begin e(0,0,0); e(1,'hA0,0); e(3,0,0); end
        run(0, 0, 1, 0, 0, 1, 10, "R6", 0, el);
        chk(el >= 36000 && el <= 36400, "R6", "total backoff cycles", el, 36000);
        // R7: one refused data byte, then a full restart
        nack_mode = 1; nack_list.push_back(3);
        e(0,0,0); e(1,'hA0,0); e(1,5,0); e(1,wd(0),0); e(1,wd(1),0); e(3,0,0);
        e_write(5, 2, 0);
        chk_gap = 1; run(1, 5, 2, 0, 15, 0, 0, "R7", 0, el);
        // R7: data refused on every attempt
        nack_mode = 2;
        for (int i = 0; i < 10; i++) begin e(0,0,0); e(1,'hA0,0); e(1,5,0); e(1,wd(0),0); e(3,0,0); end
        run(1, 5, 1, 0, 10, 2, 0, "R7", 0, el);
        // R8: range and empty requests
        run(0, 2048, 4, 0, 0, 3, -1, "R8", 0, el);
        run(1, 0, 4, 3, 0, 3, -1, "R8", 0, el);
        run(1, 100, 0, 0, 0, 0, -1, "R8", 0, el);
        // R9: request while busy is ignored
        e_read('h20, 6, 0); run(0, 'h20, 6, 0, 0, 0, 0, "R9", 1, el);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule